// File: doc/BRIEF.md
# Three-and-a-half digit static LCD segment driver

This block takes a finished meter reading and produces the drive lines for a static, non-multiplexed liquid crystal panel. The reading is three BCD digits (units, tens, hundreds), a single bit for the leading "1" and a flag for a negative value. Each BCD digit is decoded to seven segments. The leading digit has one line that lights segments A and B together, and a separate line lights the minus sign.

Liquid crystal must see no net DC. The block therefore derives a 50% duty square-wave backplane from the oscillator clock and drives every segment line as the XOR of its lit state with the next backplane value. An unlit segment follows the backplane, and a lit one runs in antiphase. All segment flops and the backplane flop load on the same clock edge, so the pair never disagrees for even one cycle. A test input lights the whole panel. The reset input is asserted asynchronously and is released in step with the clock.

Top module: `lcd_seg_drv`

## Requirements
- R1: While reset is active, `bp_o` is 0 and all 23 bits of `seg_o` are 0.
- R2: `bp_o` is a square wave that holds each level for exactly `BP_HALF` clock cycles (default 400, so the backplane runs at the clock rate divided by 800).
- R3: For every segment bit, `seg_o[k]` equals `bp_o` when that segment is unlit and equals the inverse of `bp_o` when it is lit.
- R4: The segment bits are laid out as units in `seg_o[6:0]`, tens in `seg_o[13:7]` and hundreds in `seg_o[20:14]`, with segment A at the low bit of each group and G at the high bit. Digits 0 to 9 light the 7-bit patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex, G..A).
- R5: A BCD input from 10 to 15 leaves all seven segments of that digit unlit.
- R6: `seg_o[21]` is the shared A/B segment of the leading digit, and it is lit exactly when `thou_i` is 1.
- R7: `seg_o[22]` is the minus sign, and it is lit exactly when `neg_i` is 1. This holds also when all three digits are zero.
- R8: When `test_i` is 1, all 23 segments are lit, whatever the other inputs are.
- R9: A change at the inputs appears at `seg_o` after exactly one rising clock edge, and the segment lines invert on the same edge on which `bp_o` toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| units_i | input | 4 | Units digit, BCD |
| tens_i | input | 4 | Tens digit, BCD |
| hund_i | input | 4 | Hundreds digit, BCD |
| thou_i | input | 1 | Leading "1" of the half digit |
| neg_i | input | 1 | Reading is negative |
| test_i | input | 1 | Light every segment |
| seg_o | output | 23 | Segment drive lines |
| bp_o | output | 1 | Backplane square wave |

## Verification
Every segment result is due one rising edge after its inputs change. The backplane toggles once per `BP_HALF` edges, and on that same edge every segment line inverts. The bench sets its inputs on a falling edge and reads on the next falling edge, so exactly one rising edge lies between stimulus and sample. It compares the segment lines XOR the backplane against the expected lit pattern. It also waits for a backplane toggle and checks the raw lines at the first falling edge after it. The backplane half-period is measured by counting falling edges between toggles.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int BCD_W         = 4;
  localparam int SEG_PER_DIGIT = 7;
  localparam int FULL_DIGITS   = 3;
  localparam int IDX_THOU      = FULL_DIGITS * SEG_PER_DIGIT;
  localparam int IDX_MINUS     = IDX_THOU + 1;
  localparam int SEG_TOTAL     = IDX_MINUS + 1;

  typedef logic [SEG_PER_DIGIT-1:0] seg7_t;
  typedef logic [SEG_TOTAL-1:0]     segvec_t;
  typedef logic [BCD_W-1:0]         bcd_t;
endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/lcd_bp_gen.sv
module lcd_bp_gen #(
  parameter int HALF = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bp_next_o,
  output logic bp_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bp_q, bp_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
    bp_d  = bp_q ^ wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bp_q  <= bp_d;
    end
  end

  assign bp_next_o = bp_d;
  assign bp_o      = bp_q;
endmodule

// File: rtl/lcd_bcd7.sv
module lcd_bcd7
  import lcd_drv_pkg::*;
(
  input  bcd_t  bcd_i,
  output seg7_t seg_o
);
  always_comb begin
    unique case (bcd_i)
      4'd0:    seg_o = 7'h3F;
      4'd1:    seg_o = 7'h06;
      4'd2:    seg_o = 7'h5B;
      4'd3:    seg_o = 7'h4F;
      4'd4:    seg_o = 7'h66;
      4'd5:    seg_o = 7'h6D;
      4'd6:    seg_o = 7'h7D;
      4'd7:    seg_o = 7'h07;
      4'd8:    seg_o = 7'h7F;
      4'd9:    seg_o = 7'h6F;
      default: seg_o = 7'h00; // R5: codes above nine stay dark
    endcase
  end
endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_drv_pkg::*;
#(
  parameter int BP_HALF = 400
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BCD_W-1:0]     units_i,
  input  logic [BCD_W-1:0]     tens_i,
  input  logic [BCD_W-1:0]     hund_i,
  input  logic                 thou_i,
  input  logic                 neg_i,
  input  logic                 test_i,
  output logic [SEG_TOTAL-1:0] seg_o,
  output logic                 bp_o
);
  logic rst_sync_n;
  logic bp_d, bp_q;

  lcd_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  lcd_bp_gen #(.HALF(BP_HALF)) u_bp (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .bp_next_o (bp_d),
    .bp_o      (bp_q)
  );

  bcd_t  digit_w [FULL_DIGITS];
  seg7_t glyph_w [FULL_DIGITS];

  assign digit_w[0] = units_i;
  assign digit_w[1] = tens_i;
  assign digit_w[2] = hund_i;

  for (genvar g = 0; g < FULL_DIGITS; g++) begin : g_dec
    lcd_bcd7 u_dec (
      .bcd_i (digit_w[g]),
      .seg_o (glyph_w[g])
    );
  end

  segvec_t lit_d, seg_d, seg_q;

  always_comb begin
    lit_d = '0;
    for (int k = 0; k < FULL_DIGITS; k++) begin
      lit_d[k*SEG_PER_DIGIT +: SEG_PER_DIGIT] = glyph_w[k];
    end
    lit_d[IDX_THOU]  = thou_i;
    lit_d[IDX_MINUS] = neg_i;
    if (test_i) lit_d = '1;
    // R9: combine with the value the backplane takes on this same edge
    seg_d = lit_d ^ {SEG_TOTAL{bp_d}};
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) seg_q <= '0;
    else             seg_q <= seg_d;
  end

  assign seg_o = seg_q;
  assign bp_o  = bp_q;
endmodule

// File: rtl/lcd_seg_drv_chk.sv
module lcd_seg_drv_chk
  import lcd_drv_pkg::*;
#(
  parameter int BP_HALF = 400
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [BCD_W-1:0]     units_i,
  input logic [BCD_W-1:0]     tens_i,
  input logic [BCD_W-1:0]     hund_i,
  input logic                 thou_i,
  input logic                 neg_i,
  input logic                 test_i,
  input logic [SEG_TOTAL-1:0] seg_o,
  input logic                 bp_o
);
  localparam int CW = (BP_HALF > 1) ? $clog2(BP_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(BP_HALF - 1);

  logic [CW-1:0] ref_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ref_cnt <= '0;
    else if (ref_cnt == LAST) ref_cnt <= '0;
    else                      ref_cnt <= ref_cnt + CW'(1);
  end

  AST_RESET_DARK: assert property (@(posedge clk_i)
    !rst_ni |-> (bp_o == 1'b0 && seg_o == '0)); // R1

  AST_BP_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_cnt == LAST) |=> (bp_o != $past(bp_o))); // R2

  AST_BP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_cnt != LAST) |=> $stable(bp_o)); // R2

  AST_TEST_ALL_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> (seg_o == ~{SEG_TOTAL{bp_o}})); // R8

  AST_THOU_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |=> ((seg_o[IDX_THOU] ^ bp_o) == $past(thou_i))); // R6

  AST_MINUS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |=> ((seg_o[IDX_MINUS] ^ bp_o) == $past(neg_i))); // R7

  for (genvar g = 0; g < FULL_DIGITS; g++) begin : g_blank
    logic [BCD_W-1:0] dig;
    assign dig = (g == 0) ? units_i : ((g == 1) ? tens_i : hund_i);
    AST_BLANK_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!test_i && dig > 4'd9) |=> (seg_o[g*SEG_PER_DIGIT +: SEG_PER_DIGIT] == {SEG_PER_DIGIT{bp_o}})); // R5
  end
endmodule

bind lcd_seg_drv lcd_seg_drv_chk #(.BP_HALF(BP_HALF)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .units_i (units_i),
  .tens_i  (tens_i),
  .hund_i  (hund_i),
  .thou_i  (thou_i),
  .neg_i   (neg_i),
  .test_i  (test_i),
  .seg_o   (seg_o),
  .bp_o    (bp_o)
);

// File: tb/lcd_seg_drv_test.sv
module lcd_seg_drv_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int NV         = 11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  units, tens, hund;
  logic        thou, neg, test;
  logic [22:0] seg;
  logic        bp;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_seg_drv #(.BP_HALF(HALF)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .units_i (units),
    .tens_i  (tens),
    .hund_i  (hund),
    .thou_i  (thou),
    .neg_i   (neg),
    .test_i  (test),
    .seg_o   (seg),
    .bp_o    (bp)
  );

  // stimulus {test, neg, thou, hund, tens, units}
  localparam logic [14:0] STIM [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0},
    {1'b0, 1'b0, 1'b1, 4'h3, 4'h2, 4'h1},
    {1'b0, 1'b1, 1'b0, 4'h6, 4'h5, 4'h4},
    {1'b0, 1'b1, 1'b1, 4'h9, 4'h8, 4'h7},
    {1'b0, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0},
    {1'b0, 1'b0, 1'b0, 4'hC, 4'hB, 4'hA},
    {1'b0, 1'b0, 1'b1, 4'hF, 4'hE, 4'hD},
    {1'b0, 1'b0, 1'b0, 4'h5, 4'h0, 4'h9},
    {1'b1, 1'b0, 1'b0, 4'h8, 4'h6, 4'h3},
    {1'b1, 1'b0, 1'b0, 4'hF, 4'hF, 4'hF},
    {1'b0, 1'b0, 1'b0, 4'h1, 4'h7, 4'h2}
  };

  // expected lit pattern {minus, thou, hund, tens, units}
  localparam logic [22:0] EXP [NV] = '{
    {1'b0, 1'b0, 7'h3F, 7'h3F, 7'h3F},
    {1'b0, 1'b1, 7'h4F, 7'h5B, 7'h06},
    {1'b1, 1'b0, 7'h7D, 7'h6D, 7'h66},
    {1'b1, 1'b1, 7'h6F, 7'h7F, 7'h07},
    {1'b1, 1'b0, 7'h3F, 7'h3F, 7'h3F},
    {1'b0, 1'b0, 7'h00, 7'h00, 7'h00},
    {1'b0, 1'b1, 7'h00, 7'h00, 7'h00},
    {1'b0, 1'b0, 7'h6D, 7'h3F, 7'h6F},
    23'h7FFFFF,
    23'h7FFFFF,
    {1'b0, 1'b0, 7'h06, 7'h07, 7'h5B}
  };

  function automatic string tag_of(input int i);
    case (i)
      1, 3:    return "R4 R6";
      4:       return "R7";
      5, 6:    return "R5";
      8, 9:    return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [14:0] s);
    {test, neg, thou, hund, tens, units} = s;
  endtask

  task automatic wait_toggle(output int n);
    logic prev;
    prev = bp;
    n = 0;
    while (bp == prev && n < 4 * HALF) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    drive(STIM[3]);
    repeat (3) @(negedge clk);
    chk("R1 seg in reset", seg, 23'h0);
    chk("R1 bp in reset", {22'h0, bp}, 23'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: half-period measured twice (both levels)
    wait_toggle(n);
    wait_toggle(n);
    chk("R2 first half", 23'(n), 23'(HALF));
    wait_toggle(n);
    chk("R2 second half", 23'(n), 23'(HALF));

    for (int i = 0; i < NV; i++) begin
      drive(STIM[i]);
      @(posedge clk);
      @(negedge clk);
      chk({tag_of(i), " R3 lit pattern"}, seg ^ {23{bp}}, EXP[i]);
      wait_toggle(n);
      chk({tag_of(i), " R9 R3 after toggle"}, seg, EXP[i] ^ {23{bp}});
    end

    // R9: one-edge latency, nothing before the edge
    drive(STIM[1]);
    @(posedge clk);
    @(negedge clk);
    drive(STIM[2]);
    #1;
    chk("R9 before edge", seg ^ {23{bp}}, EXP[1]);
    @(posedge clk);
    @(negedge clk);
    chk("R9 after one edge", seg ^ {23{bp}}, EXP[2]);

    // R1: reset during operation clears at once
    drive(STIM[8]);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear seg", seg, 23'h0);
    chk("R1 async clear bp", {22'h0, bp}, 23'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 R3 after reset", seg ^ {23{bp}}, 23'h7FFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule